// File: doc/BRIEF.md
# Multi-Source Acquisition Trigger Unit

This block decides when a four-channel sampling pipeline should fire. It produces a one-cycle trigger pulse from one of three places. The first is a threshold crossing on a chosen input channel. The second is a dedicated external trigger pin. The third is a software write strobe. Only one of the two hardware sources is active at a time. Each hardware source can fire on a rising or a falling edge. The software strobe is always OR-ed in.

The threshold path compares the chosen channel sample, as a signed two's complement number, against a signed threshold. The result can pass through a persistence filter. That filter changes its output only after the raw comparison has held a new level for a set number of consecutive samples. The external pin goes through a synchroniser before edge detection.

For tuning the filter, a diagnostic mode replaces output channels 2, 3 and 4 with the raw comparison, the filtered comparison and the trigger. Channel data passes through one register stage in both modes. All configuration inputs are assumed to be already in the sampling clock domain.

Top module: `trig_unit`

## Requirements
- R1: With source select 0 (threshold), the sample of channel `src_chan_i`+1 is compared against `thresh_i`, and the other channels have no effect. The flag is 1 when the sample is strictly greater than the threshold. A rising edge of that flag fires `trig_o` two clock edges after the sample is presented.
- R2: The sample and the threshold are both compared as signed two's complement values. For example, sample 10 is above threshold -5, and sample -20 is below it.
- R3: `edge_fall_i` = 0 selects rising-edge detection and 1 selects falling-edge detection, for either hardware source. An edge of the other direction produces no trigger.
- R4: With source select 1 (external), `ext_trig_i` passes through a two-flop synchroniser and then the edge detector. A pulse one cycle wide produces exactly one trigger.
- R5: With `filt_len_i` = N > 0, the filtered flag takes a new raw level only after that level has been present for N consecutive samples. A raw excursion shorter than N samples produces no trigger.
- R6: With `filt_len_i` = 0, the filter is bypassed and the raw flag drives the edge detector directly.
- R7: A comparison level that stays held produces one trigger, not a repeated one.
- R8: Each cycle with `sw_trig_i` high produces `trig_o` high on the next cycle, regardless of the hardware path.
- R9: Output channel data is the input channel data delayed by one register stage. In diagnostic mode, channel 2 carries the previous raw flag, channel 3 the filtered flag, and channel 4 the trigger value, each zero-extended in bit 0. Channel 4 then equals `trig_o` in the same cycle.
- R10: During and right after synchronous reset, `trig_o` and `ch_data_o` are 0.
- R11: A hardware trigger lasts exactly one cycle while the polarity setting is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_data_i | input | 64 | Four 16-bit samples; channel 1 in bits 15:0 |
| ext_trig_i | input | 1 | Asynchronous external trigger pin |
| src_ext_i | input | 1 | 0 = threshold source, 1 = external source |
| edge_fall_i | input | 1 | 0 = rising edge, 1 = falling edge |
| src_chan_i | input | 2 | Threshold channel index (0 = channel 1) |
| thresh_i | input | 16 | Signed threshold |
| filt_len_i | input | 8 | Persistence length; 0 bypasses the filter |
| diag_en_i | input | 1 | Diagnostic channel replacement enable |
| sw_trig_i | input | 1 | Software trigger write strobe |
| trig_o | output | 1 | Trigger pulse |
| ch_data_o | output | 64 | Registered channel data, possibly replaced by diagnostics |

## Verification
A wrong persistence counter shows up at `trig_o` as a missing trigger, or as one fired on a short glitch. In diagnostic mode it also shows on channel 3 within a sample of the mistake. A stale edge-history register shows as a repeated or missing pulse on the next level change. The bench's reference model compares `trig_o` and all four channels every cycle, so any divergence is reported in the cycle it reaches the ports. Directed trigger counts per phase tie each corner case to its requirement.

// File: rtl/trg_pkg.sv
package trg_pkg;

    typedef enum logic {
        TRG_SRC_THRESH = 1'b0,
        TRG_SRC_EXT    = 1'b1
    } trg_src_e;

    typedef enum logic {
        TRG_EDGE_RISE = 1'b0,
        TRG_EDGE_FALL = 1'b1
    } trg_edge_e;

    typedef struct packed {
        logic over_raw;
        logic over_filt;
        logic fire;
    } trg_diag_t;

    function automatic logic edge_hit(input logic now, input logic prev, input trg_edge_e pol);
        return (pol == TRG_EDGE_FALL) ? (!now && prev) : (now && !prev);
    endfunction

    function automatic logic [15:0] flag_word(input logic flag);
        return {15'd0, flag};
    endfunction

endpackage

// File: rtl/trg_sync.sv
module trg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= 1'b0;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/trg_glitch.sv
module trg_glitch #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] len_i,
    input  logic             raw_i,
    output logic             filt_o
);
    logic [LEN_W-1:0] run_q;
    logic             held_q;
    logic [LEN_W:0]   run_nxt;

    assign run_nxt = {1'b0, run_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            held_q <= 1'b0;
        end else if (len_i == '0) begin
            run_q  <= '0;
            held_q <= raw_i;
        end else if (raw_i == held_q) begin
            run_q  <= '0;
        end else if (run_nxt >= {1'b0, len_i}) begin
            run_q  <= '0;
            held_q <= raw_i;
        end else begin
            run_q  <= run_nxt[LEN_W-1:0];
        end
    end

    assign filt_o = (len_i == '0) ? raw_i : held_q;

    // R5: a fresh disagreement cannot flip the held level when length exceeds one
    p_persist_r5: assert property (@(posedge clk) disable iff (rst)
        (len_i > 1 && raw_i != held_q && run_q == '0) |=> (held_q == $past(held_q)));
endmodule

// File: rtl/trg_edge.sv
module trg_edge
    import trg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      lvl_i,
    input  trg_edge_e pol_i,
    output logic      hit_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl_i;
    end

    assign hit_o = edge_hit(lvl_i, prev_q, pol_i);

    // R11: with polarity unchanged a hit is never followed by another hit
    p_one_hit_r11: assert property (@(posedge clk) disable iff (rst)
        hit_o |=> (!hit_o || pol_i != $past(pol_i)));
endmodule

// File: rtl/trig_unit.sv
module trig_unit
    import trg_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_CH   = 4,
    parameter int LEN_W    = 8,
    parameter int SYNC_LEN = 2,
    localparam int SEL_W   = $clog2(NUM_CH),
    localparam int BUS_W   = DATA_W * NUM_CH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] ch_data_i,
    input  logic             ext_trig_i,
    input  logic             src_ext_i,
    input  logic             edge_fall_i,
    input  logic [SEL_W-1:0] src_chan_i,
    input  logic [DATA_W-1:0] thresh_i,
    input  logic [LEN_W-1:0] filt_len_i,
    input  logic             diag_en_i,
    input  logic             sw_trig_i,
    output logic             trig_o,
    output logic [BUS_W-1:0] ch_data_o
);
    trg_src_e  src;
    trg_edge_e pol;
    assign src = trg_src_e'(src_ext_i);
    assign pol = trg_edge_e'(edge_fall_i);

    logic signed [DATA_W-1:0] pick;
    logic      over_q;
    logic      ext_s;
    logic      lvl;
    logic      hw_hit;
    logic      fire_nxt;
    trg_diag_t diag;

    assign pick = $signed(ch_data_i[src_chan_i*DATA_W +: DATA_W]);

    always_ff @(posedge clk) begin
        if (rst) over_q <= 1'b0;
        else     over_q <= pick > $signed(thresh_i);
    end

    trg_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst(rst), .async_i(ext_trig_i), .sync_o(ext_s)
    );

    trg_glitch #(.LEN_W(LEN_W)) u_glitch (
        .clk(clk), .rst(rst), .len_i(filt_len_i), .raw_i(over_q), .filt_o(diag.over_filt)
    );

    assign diag.over_raw = over_q;
    assign lvl = (src == TRG_SRC_EXT) ? ext_s : diag.over_filt;

    trg_edge u_edge (
        .clk(clk), .rst(rst), .lvl_i(lvl), .pol_i(pol), .hit_o(hw_hit)
    );

    assign fire_nxt  = hw_hit | sw_trig_i;
    assign diag.fire = fire_nxt;

    always_ff @(posedge clk) begin
        if (rst) trig_o <= 1'b0;
        else     trig_o <= fire_nxt;
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            logic [DATA_W-1:0] word;
            always_comb begin
                word = ch_data_i[c*DATA_W +: DATA_W];
                if (diag_en_i) begin
                    if (c == 1) word = DATA_W'(flag_word(diag.over_raw));
                    if (c == 2) word = DATA_W'(flag_word(diag.over_filt));
                    if (c == 3) word = DATA_W'(flag_word(diag.fire));
                end
            end
            always_ff @(posedge clk) begin
                if (rst) ch_data_o[c*DATA_W +: DATA_W] <= '0;
                else     ch_data_o[c*DATA_W +: DATA_W] <= word;
            end
        end
    endgenerate

    // R8: a software strobe always shows on the trigger next cycle
    p_sw_fire_r8: assert property (@(posedge clk) disable iff (rst)
        sw_trig_i |=> trig_o);

    // R9: in diagnostic mode the fourth channel mirrors the trigger output
    p_diag_ch4_r9: assert property (@(posedge clk) disable iff (rst)
        $past(diag_en_i) |-> (ch_data_o[3*DATA_W +: DATA_W] == DATA_W'(trig_o)));

    // R10: reset clears the outputs on the following edge
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (!trig_o && ch_data_o == '0));
endmodule

// File: tb/trig_unit_tb.sv
module trig_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] ch_data_i;
    logic        ext_trig_i, src_ext_i, edge_fall_i, diag_en_i, sw_trig_i;
    logic [1:0]  src_chan_i;
    logic [15:0] thresh_i;
    logic [7:0]  filt_len_i;
    logic        trig_o;
    logic [63:0] ch_data_o;

    logic signed [15:0] smp [4];
    assign ch_data_i = {smp[3], smp[2], smp[1], smp[0]};

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_unit u_dut (
        .clk(clk), .rst(rst), .ch_data_i(ch_data_i), .ext_trig_i(ext_trig_i),
        .src_ext_i(src_ext_i), .edge_fall_i(edge_fall_i), .src_chan_i(src_chan_i),
        .thresh_i(thresh_i), .filt_len_i(filt_len_i), .diag_en_i(diag_en_i),
        .sw_trig_i(sw_trig_i), .trig_o(trig_o), .ch_data_o(ch_data_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    int trig_cnt = 0;
    int hw_run = 0;
    int hw_run_max = 0;
    int cycles = 0;
    string cur_req = "R10";

    // reference model state
    int m_over, m_held, m_run, m_prev, m_s1, m_s2, m_trig, m_sw_prev;
    int m_ch [4];

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int sval, thr, filt, lvl, hit, nt;
        if (rst) begin
            m_over = 0; m_held = 0; m_run = 0; m_prev = 0; m_s1 = 0; m_s2 = 0;
            m_trig = 0; m_sw_prev = 0;
            for (int i = 0; i < 4; i++) m_ch[i] = 0;
        end else begin
            sval = smp[src_chan_i];
            thr  = $signed(thresh_i);
            filt = (filt_len_i == 0) ? m_over : m_held;
            lvl  = src_ext_i ? m_s2 : filt;
            hit  = edge_fall_i ? (lvl == 0 && m_prev == 1) : (lvl == 1 && m_prev == 0);
            nt   = (hit != 0 || sw_trig_i) ? 1 : 0;
            m_ch[0] = int'(smp[0]) & 16'hFFFF;
            m_ch[1] = diag_en_i ? m_over : (int'(smp[1]) & 16'hFFFF);
            m_ch[2] = diag_en_i ? filt   : (int'(smp[2]) & 16'hFFFF);
            m_ch[3] = diag_en_i ? nt     : (int'(smp[3]) & 16'hFFFF);
            if (filt_len_i == 0) begin
                m_held = m_over; m_run = 0;
            end else if (m_over == m_held) begin
                m_run = 0;
            end else if (m_run + 1 >= filt_len_i) begin
                m_held = m_over; m_run = 0;
            end else begin
                m_run = m_run + 1;
            end
            m_sw_prev = sw_trig_i;
            m_trig = nt;
            m_over = (sval > thr) ? 1 : 0;
            m_prev = lvl;
            m_s2 = m_s1;
            m_s1 = ext_trig_i;
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            chk(cur_req, trig_o, m_trig);
            for (int i = 0; i < 4; i++)
                chk(cur_req, ch_data_o[i*16 +: 16], m_ch[i]);
            if (trig_o) trig_cnt++;
            if (trig_o && !m_sw_prev) hw_run++; else hw_run = 0;
            if (hw_run > hw_run_max) hw_run_max = hw_run;
        end
        if (cycles > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int base;
        rst = 1'b1; ext_trig_i = 0; src_ext_i = 0; edge_fall_i = 0; diag_en_i = 0;
        sw_trig_i = 0; src_chan_i = 2'd1; thresh_i = 16'sd100; filt_len_i = 0;
        for (int i = 0; i < 4; i++) smp[i] = 0;
        run(4);
        chk("R10", trig_o, 0);
        chk("R10", ch_data_o, 0);
        rst = 1'b0;

        // R1: channel 2 selected; channel 1 large but ignored
        cur_req = "R1";
        smp[0] = 16'sd500; smp[1] = 16'sd50;
        run(5);
        chk("R1", trig_cnt, 0);
        base = trig_cnt;
        smp[1] = 16'sd150;
        run(1);
        chk("R1", trig_o, 0);
        run(1);
        chk("R1", trig_o, 1);
        run(4);
        chk("R1", trig_cnt - base, 1);
        // R7: held level does not retrigger
        cur_req = "R7";
        base = trig_cnt;
        run(10);
        chk("R7", trig_cnt - base, 0);

        // R2: signed comparison
        cur_req = "R2";
        thresh_i = 16'hFFFB;
        smp[1] = -16'sd20;
        run(5);
        base = trig_cnt;
        smp[1] = 16'sd10;
        run(5);
        chk("R2", trig_cnt - base, 1);
        smp[1] = -16'sd20;
        run(5);

        // R3: falling-edge polarity
        cur_req = "R3";
        edge_fall_i = 1;
        run(3);
        base = trig_cnt;
        smp[1] = 16'sd10;
        run(5);
        chk("R3", trig_cnt - base, 0);
        smp[1] = -16'sd20;
        run(5);
        chk("R3", trig_cnt - base, 1);

        // R4: external source through synchroniser
        cur_req = "R4";
        src_ext_i = 1; edge_fall_i = 0;
        run(4);
        base = trig_cnt;
        ext_trig_i = 1; run(1); ext_trig_i = 0;
        run(2);
        chk("R4", trig_o, 1);
        run(5);
        chk("R4", trig_cnt - base, 1);
        edge_fall_i = 1;
        run(3);
        base = trig_cnt;
        ext_trig_i = 1; run(3); ext_trig_i = 0;
        run(6);
        chk("R4", trig_cnt - base, 1);

        // R5: persistence filter length 4
        cur_req = "R5";
        src_ext_i = 0; edge_fall_i = 0; filt_len_i = 8'd4;
        smp[1] = -16'sd20;
        run(8);
        base = trig_cnt;
        smp[1] = 16'sd10; run(2); smp[1] = -16'sd20;
        run(8);
        chk("R5", trig_cnt - base, 0);
        base = trig_cnt;
        smp[1] = 16'sd10;
        run(10);
        chk("R5", trig_cnt - base, 1);
        smp[1] = -16'sd20;
        run(10);

        // R6: bypass reacts to a single-sample excursion
        cur_req = "R6";
        filt_len_i = 0;
        run(3);
        base = trig_cnt;
        smp[1] = 16'sd10; run(1); smp[1] = -16'sd20;
        run(5);
        chk("R6", trig_cnt - base, 1);

        // R8: software strobe
        cur_req = "R8";
        base = trig_cnt;
        sw_trig_i = 1; run(1); sw_trig_i = 0;
        chk("R8", trig_o, 1);
        run(4);
        chk("R8", trig_cnt - base, 1);

        // R9: diagnostic channel replacement with filter active
        cur_req = "R9";
        diag_en_i = 1; filt_len_i = 8'd3;
        smp[0] = 16'sh1234; smp[2] = 16'sh0F0F; smp[3] = 16'sh7777;
        run(3);
        smp[1] = 16'sd10; run(2); smp[1] = -16'sd20; run(4);
        smp[1] = 16'sd10; run(8);
        smp[1] = -16'sd20; run(6);
        chk("R9", ch_data_o[63:48], 16'(trig_o));
        diag_en_i = 0;
        smp[2] = 16'sd1234; smp[3] = -16'sd7;
        run(2);
        chk("R9", ch_data_o[47:32], 1234);
        chk("R9", ch_data_o[63:48], 16'hFFF9);

        cur_req = "R11";
        chk("R11", hw_run_max, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule